// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two pointer register sets for an 8051-style core, plus one select register that decides which set is active. Each set is three bytes wide: low, high and extension. The core sends single-cycle strobes to step the active pointer, to load it with an immediate value, or to mark that it was used as an address for a table read or an external access. The block presents the active pointer on a combinational address output, either 16 or 24 bits wide.

The width is chosen by an input flag. When the flag is set, the extension byte takes part in the arithmetic and in the address. When it is clear, only the high and low bytes move and the extension byte keeps its value.

Three bits of the select register set the behaviour:
- Bit 0 picks the active set.
- Bit 7 makes a step count down instead of up.
- Bit 5 flips bit 0 after every pointer-using command, so that code can walk two buffers in turn.

Software writes any register through a direct write port and reads any register through an indexed readback port. All pins are plain control and data signals. Each strobe acts in exactly the cycle it is high, so there is no back-pressure.

Top module: `ddp_unit`

## Requirements
- R1: After reset the select register reads 0x04 and all six pointer bytes read 0x00.
- R2: Select bit 0 chooses the active set: 0 is the primary set (indices 1..3) and 1 is the secondary set (indices 4..6). Commands and the address output use only the active set.
- R3: A step command increments the active pointer when select bit 7 is 0, and decrements it when select bit 7 is 1. The result is visible after the next clock edge.
- R4: With the 24-bit flag set, steps act on {ext,high,low} modulo 2^24, and the address output is ext*65536 + high*256 + low.
- R5: With the 24-bit flag clear, steps act on {high,low} modulo 2^16, the extension byte is unchanged, and the upper byte of the address output is 0.
- R6: A load command copies ld_data_i[23:0] as {ext,high,low} into the active set when the 24-bit flag is set. When the flag is clear it copies only bits [15:0] into {high,low} and leaves the extension byte unchanged.
- R7: A direct write to the select register (index 0) stores (data AND 0xE5) OR 0x04.
- R8: When select bit 5 is 1, every step, load or use command flips select bit 0 at the same clock edge as the pointer update. When bit 5 is 0, select bit 0 is unchanged.
- R9: Readback index map: 0 select, 1 primary low, 2 primary high, 3 primary ext, 4 secondary low, 5 secondary high, 6 secondary ext. Index 7 reads 0x00 and writes to it are ignored.
- R10: In a cycle where wr_en_i is high, any step, load or use strobe is ignored. Only the direct write takes effect, and there is no pointer change and no toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode24_i | input | 1 | 1 selects 24-bit pointer width |
| step_i | input | 1 | Step strobe for the active pointer |
| load_i | input | 1 | Load-immediate strobe |
| use_i | input | 1 | Pointer used as address (table read or external access) |
| ld_data_i | input | 24 | Immediate value {ext,high,low} |
| wr_en_i | input | 1 | Direct register write enable |
| wr_idx_i | input | 3 | Register index for the direct write |
| wr_data_i | input | 8 | Direct write data |
| rd_idx_i | input | 3 | Register index for readback |
| rd_data_o | output | 8 | Readback data |
| addr_o | output | 24 | Effective address from the active pointer |

## Verification
The bench builds the block with the default byte width of 8, so a pointer is 24 bits wide and both wrap boundaries are reached with a single step. The bench first loads all-ones or all-zeros, then steps once in each direction in both width modes. Because the select register can be written directly, the bench can try every combination of the select, direction and toggle bits, and can check the collision between a direct write and a command strobe in one cycle.

// File: rtl/ddp_pkg.sv
package ddp_pkg;
  // bit positions inside the select register
  localparam int SEL_BIT = 0;
  localparam int TOG_BIT = 5;
  localparam int DEC_BIT = 7;
  // select write masking
  localparam logic [7:0] SEL_KEEP  = 8'hE5;
  localparam logic [7:0] SEL_FORCE = 8'h04;
  // register index map
  typedef enum logic [2:0] {
    IDX_SEL  = 3'd0,
    IDX_LO0  = 3'd1,
    IDX_HI0  = 3'd2,
    IDX_EXT0 = 3'd3,
    IDX_LO1  = 3'd4,
    IDX_HI1  = 3'd5,
    IDX_EXT1 = 3'd6,
    IDX_NONE = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/ddp_ptr_bank.sv
module ddp_ptr_bank #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode24,
  input  logic            act,
  input  logic            step,
  input  logic            dec,
  input  logic            load,
  input  logic [3*BW-1:0] ld_data,
  input  logic [2:0]      wr_oh,
  input  logic [BW-1:0]   wr_data,
  output logic [BW-1:0]   lo,
  output logic [BW-1:0]   hi,
  output logic [BW-1:0]   ext
);
  localparam int AW = 3 * BW;
  localparam int HW = 2 * BW;

  logic [AW-1:0] full, full_nx;
  logic [HW-1:0] half_nx;

  assign full = {ext, hi, lo};

  always_comb begin
    full_nx = dec ? full - AW'(1) : full + AW'(1);
    half_nx = dec ? full[HW-1:0] - HW'(1) : full[HW-1:0] + HW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo  <= '0;
      hi  <= '0;
      ext <= '0;
    end else if (|wr_oh) begin
      if (wr_oh[0]) lo  <= wr_data;
      if (wr_oh[1]) hi  <= wr_data;
      if (wr_oh[2]) ext <= wr_data;
    end else if (act && load) begin
      if (mode24) ext <= ld_data[AW-1:HW];
      {hi, lo} <= ld_data[HW-1:0];
    end else if (act && step) begin
      if (mode24) {ext, hi, lo} <= full_nx;
      else        {hi, lo}      <= half_nx;
    end
  end

  // R5
  ext_hold16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (step || load) && !mode24 && !(|wr_oh)) |=> $stable(ext));

  // R4
  wrap24_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && step && !load && mode24 && !dec && !(|wr_oh) && (&full))
      |=> ({ext, hi, lo} == '0));

  // R3
  inc16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && step && !load && !mode24 && !dec && !(|wr_oh))
      |=> ({hi, lo} == $past(full[HW-1:0]) + HW'(1)));
endmodule

// File: rtl/ddp_select.sv
module ddp_select
  import ddp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wr_data,
  input  logic       used,
  output logic [7:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sel <= SEL_FORCE;
    else if (wr)
      sel <= (wr_data & SEL_KEEP) | SEL_FORCE;
    else if (used && sel[TOG_BIT])
      sel[SEL_BIT] <= ~sel[SEL_BIT];
  end

  // R7
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel[2] && !sel[1] && !sel[3] && !sel[4]);

  // R8
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used && !wr && sel[TOG_BIT]) |=> (sel[SEL_BIT] != $past(sel[SEL_BIT])));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !(used && sel[TOG_BIT])) |=> $stable(sel));
endmodule

// File: rtl/ddp_unit.sv
module ddp_unit
  import ddp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode24_i,
  input  logic                step_i,
  input  logic                load_i,
  input  logic                use_i,
  input  logic [3*BYTE_W-1:0] ld_data_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_idx_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [2:0]          rd_idx_i,
  output logic [BYTE_W-1:0]   rd_data_o,
  output logic [3*BYTE_W-1:0] addr_o
);
  localparam int NSETS = 2;

  logic [7:0]        sel;
  logic              step_g, load_g, use_g, used;
  logic [BYTE_W-1:0] lo_a  [NSETS];
  logic [BYTE_W-1:0] hi_a  [NSETS];
  logic [BYTE_W-1:0] ext_a [NSETS];

  // a direct write blocks every command in its cycle
  assign step_g = step_i & ~wr_en_i;
  assign load_g = load_i & ~wr_en_i;
  assign use_g  = use_i  & ~wr_en_i;
  assign used   = step_g | load_g | use_g;

  ddp_select u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_en_i && (wr_idx_i == IDX_SEL)),
    .wr_data (wr_data_i[7:0]),
    .used    (used),
    .sel     (sel)
  );

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic [2:0] wr_oh;
    assign wr_oh[0] = wr_en_i && (wr_idx_i == 3'(1 + 3*g));
    assign wr_oh[1] = wr_en_i && (wr_idx_i == 3'(2 + 3*g));
    assign wr_oh[2] = wr_en_i && (wr_idx_i == 3'(3 + 3*g));

    ddp_ptr_bank #(.BW(BYTE_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode24  (mode24_i),
      .act     (sel[SEL_BIT] == 1'(g)),
      .step    (step_g),
      .dec     (sel[DEC_BIT]),
      .load    (load_g),
      .ld_data (ld_data_i),
      .wr_oh   (wr_oh),
      .wr_data (wr_data_i),
      .lo      (lo_a[g]),
      .hi      (hi_a[g]),
      .ext     (ext_a[g])
    );
  end

  always_comb begin
    unique case (reg_idx_e'(rd_idx_i))
      IDX_SEL:  rd_data_o = BYTE_W'(sel);
      IDX_LO0:  rd_data_o = lo_a[0];
      IDX_HI0:  rd_data_o = hi_a[0];
      IDX_EXT0: rd_data_o = ext_a[0];
      IDX_LO1:  rd_data_o = lo_a[1];
      IDX_HI1:  rd_data_o = hi_a[1];
      IDX_EXT1: rd_data_o = ext_a[1];
      default:  rd_data_o = '0;
    endcase
  end

  always_comb begin
    if (mode24_i)
      addr_o = {ext_a[sel[SEL_BIT]], hi_a[sel[SEL_BIT]], lo_a[sel[SEL_BIT]]};
    else
      addr_o = {{BYTE_W{1'b0}}, hi_a[sel[SEL_BIT]], lo_a[sel[SEL_BIT]]};
  end

  // R10
  wr_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (wr_idx_i == IDX_NONE) && $stable(mode24_i)) |=> ($stable(sel) && $stable(addr_o)));

  // R5
  addr16_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode24_i |-> (addr_o[3*BYTE_W-1:2*BYTE_W] == '0));
endmodule

// File: tb/ddp_unit_bench.sv
module ddp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode24_i = 1'b0;
  logic        step_i = 1'b0, load_i = 1'b0, use_i = 1'b0;
  logic [23:0] ld_data_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [7:0]  rd_data_o;
  logic [23:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ddp_unit u_ddp_unit (
    .clk(clk), .rst_n(rst_n), .mode24_i(mode24_i),
    .step_i(step_i), .load_i(load_i), .use_i(use_i),
    .ld_data_i(ld_data_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .addr_o(addr_o)
  );

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] v);
    rd_idx_i = idx;
    #1;
    v = rd_data_o;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    check(req, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic cmd(input bit s, input bit l, input bit u, input logic [23:0] d);
    @(negedge clk);
    step_i = s; load_i = l; use_i = u; ld_data_i = d;
    @(negedge clk);
    step_i = 0; load_i = 0; use_i = 0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++)
      rd_chk(i == 0 ? "R1 sel" : (i == 7 ? "R9 idx7" : "R1 byte"), 3'(i), i == 0 ? 8'h04 : 8'h00);
    check("R1 addr", addr_o, 24'h0);
  endtask

  task automatic t_sel_write;
    wr(3'd0, 8'hFF);
    rd_chk("R7 mask ff", 3'd0, 8'hE5);
    wr(3'd0, 8'h00);
    rd_chk("R7 force bit2", 3'd0, 8'h04);
    wr(3'd7, 8'h5A);
    rd_chk("R9 idx7 write ignored", 3'd7, 8'h00);
  endtask

  task automatic t_load;
    mode24_i = 1;
    cmd(0, 1, 0, 24'h123456);
    rd_chk("R6 lo", 3'd1, 8'h56);
    rd_chk("R6 hi", 3'd2, 8'h34);
    rd_chk("R6 ext", 3'd3, 8'h12);
    check("R4 addr24", addr_o, 24'h123456);
    mode24_i = 0;
    cmd(0, 1, 0, 24'hAB9876);
    rd_chk("R6 ext kept", 3'd3, 8'h12);
    check("R5 addr16", addr_o, 24'h009876);
  endtask

  task automatic t_step16;
    mode24_i = 0;
    cmd(0, 1, 0, 24'h00FFFF);
    cmd(1, 0, 0, 24'h0);
    check("R5 wrap16", addr_o, 24'h000000);
    rd_chk("R5 ext unchanged", 3'd3, 8'h12);
    wr(3'd0, 8'h84);
    cmd(1, 0, 0, 24'h0);
    check("R3 dec16", addr_o, 24'h00FFFF);
    rd_chk("R5 ext unchanged dec", 3'd3, 8'h12);
  endtask

  task automatic t_step24;
    mode24_i = 1;
    wr(3'd0, 8'h04);
    cmd(0, 1, 0, 24'hFFFFFF);
    cmd(1, 0, 0, 24'h0);
    check("R4 wrap24 up", addr_o, 24'h000000);
    wr(3'd0, 8'h84);
    cmd(1, 0, 0, 24'h0);
    check("R3 R4 wrap24 down", addr_o, 24'hFFFFFF);
    cmd(1, 0, 0, 24'h0);
    check("R3 dec24", addr_o, 24'hFFFFFE);
  endtask

  task automatic t_select;
    mode24_i = 1;
    wr(3'd0, 8'h05);
    cmd(0, 1, 0, 24'h0A0B0C);
    rd_chk("R2 sec lo", 3'd4, 8'h0C);
    rd_chk("R2 sec hi", 3'd5, 8'h0B);
    rd_chk("R2 sec ext", 3'd6, 8'h0A);
    check("R2 addr sec", addr_o, 24'h0A0B0C);
    rd_chk("R2 prim untouched", 3'd1, 8'hFE);
    wr(3'd0, 8'h04);
    check("R2 addr prim", addr_o, 24'hFFFFFE);
  endtask

  task automatic t_toggle;
    mode24_i = 1;
    wr(3'd0, 8'h24);
    cmd(0, 0, 1, 24'h0);
    rd_chk("R8 use toggles", 3'd0, 8'h25);
    cmd(1, 0, 0, 24'h0);
    rd_chk("R8 step toggles", 3'd0, 8'h24);
    check("R8 step hit secondary", addr_o, 24'hFFFFFE);
    rd_chk("R8 secondary stepped", 3'd4, 8'h0D);
    cmd(0, 1, 0, 24'h111111);
    rd_chk("R8 load toggles", 3'd0, 8'h25);
    rd_chk("R8 load into primary", 3'd2, 8'h11);
    wr(3'd0, 8'h04);
    cmd(0, 0, 1, 24'h0);
    rd_chk("R8 no toggle bit5 clear", 3'd0, 8'h04);
  endtask

  task automatic t_priority;
    mode24_i = 1;
    wr(3'd0, 8'h24);
    @(negedge clk);
    wr_en_i = 1; wr_idx_i = 3'd4; wr_data_i = 8'h77; step_i = 1; load_i = 0;
    @(negedge clk);
    wr_en_i = 0; step_i = 0;
    rd_chk("R10 write wins", 3'd4, 8'h77);
    rd_chk("R10 no toggle", 3'd0, 8'h24);
    check("R10 no step", addr_o, 24'h111111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_sel_write;
    t_load;
    t_step16;
    t_step24;
    t_select;
    t_toggle;
    t_priority;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule